// File: doc/BRIEF.md
# Serial-Bus Control Register File with Auto-Increment

This block is an I2C target that stores the control settings of an audio signal-processing chip in twenty-one byte-wide registers. A host writes to it in two steps. It first sends the device address with the write direction. It then sends a subaddress byte, which carries a 5-bit register index and three mode flags, followed by one or more data bytes. When the host uses the read direction, the block returns a status byte whose lowest bit shows whether the soft mute is active. The status is sampled again after every acknowledge, so the host can keep clocking bytes out without addressing the device again.

The mode flags change how a write behaves. One flag makes the register index advance after each data byte. Another flag stops a write to register 0 from starting the offset calibration. The third flag raises a test-mode output. The two bus lines are synchronised and de-glitched inside the block. SDA is driven only through an open-drain enable, and the register contents are presented as one flat vector to the logic that uses them.

Top module: `ctl_i2c_regfile`

## Requirements
- R1: During and after reset, every register holds 0xFE, sda_oe_o is low, cal_start_o is low and test_mode_o is low.
- R2: The address byte selects the block only when its upper seven bits are 1000110, so the full byte is 0x8C for a write and 0x8D for a read. A matching byte is acknowledged by pulling SDA low. Any other address gets no acknowledge, and the bytes that follow it are neither acknowledged nor stored.
- R3: In the subaddress byte, bits 4..0 give the register index. Each data byte that follows is stored in the register that the current index selects, and each data byte is acknowledged.
- R4: If subaddress bit 5 is 1, the index goes up by one after each data byte and stops at 31. If bit 5 is 0, every data byte of the transaction overwrites the same register.
- R5: A data byte whose index is greater than 20 is acknowledged, but no register changes.
- R6: A data byte written to index 0 produces a cal_start_o pulse exactly one clock wide, issued while the acknowledge is driven. If bit 6 of that transaction's subaddress was 1, no pulse is produced.
- R7: test_mode_o follows bit 7 of the most recently received subaddress byte.
- R8: A read returns a status byte with bit 0 equal to mute_active_i and bits 7..1 equal to zero. The value is sampled again after every acknowledge from the host, so consecutive bytes of one read can differ. A not-acknowledge from the host ends the read, and the block releases SDA.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles after synchronisation has no effect on the transfer.

Top module parameters: DEV_ADDR, NUM_REGS, RST_VAL, SYNC_STAGES, FILT_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received from the pad |
| sda_i | input | 1 | Bus data line as received from the pad |
| sda_oe_o | output | 1 | Open-drain enable; a 1 pulls SDA low |
| mute_active_i | input | 1 | Soft-mute-active flag reported in status bit 0 |
| cal_start_o | output | 1 | One-clock pulse that starts the offset calibration |
| test_mode_o | output | 1 | Test-mode flag taken from the last subaddress |
| regs_o | output | NUM_REGS*8 | All registers; register k occupies bits 8k+7..8k |

## Verification
The checker watches four things on every cycle. The calibration pulse must last one cycle and must coincide with the acknowledge. No register may change unless SDA is being pulled low. At most one register may change at a time. When reset releases, every register must hold the default value.

The checker cannot tell whether the index advanced correctly, whether a foreign address was ignored, whether the hold flag worked, whether the status byte was sampled again, or whether a glitch was rejected. Only the bench's complete bus transactions can show these, so the bench checks them against a register model that it keeps itself.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
   localparam int IDX_W = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_WDATA,
      ST_RDATA
   } bus_state_t;

   typedef struct packed {
      logic             test;
      logic             hold;
      logic             ainc;
      logic [IDX_W-1:0] idx;
   } subaddr_t;
endpackage

// File: rtl/ctl_i2c_glitch_filt.sv
module ctl_i2c_glitch_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CNT_W = $clog2(FILT_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   if (FILT_LEN == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= 1'b1;
         else        dout <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout  <= 1'b1;
            cnt_q <= '0;
         end else if (sync_q[SYNC_STAGES-1] == dout) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            dout  <= sync_q[SYNC_STAGES-1];
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
   import ctl_i2c_pkg::*;
#(
   parameter int         NUM_REGS = 21,
   parameter logic [7:0] RST_VAL  = 8'hFE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   output logic [NUM_REGS*8-1:0] regs_o
);
   if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_depth
      $error("NUM_REGS must fit the subaddress index");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_o[g*8 +: 8] <= RST_VAL;
         else if (wr_en && wr_idx == IDX_W'(g))
            regs_o[g*8 +: 8] <= wr_data;
      end
   end
endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
   import ctl_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl,
   input  logic             sda,
   input  logic [7:0]       status_i,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             cal_start,
   output logic             test_mode
);
   bus_state_t       state;
   subaddr_t         sub_q;
   logic [IDX_W-1:0] ptr_q;
   logic [3:0]       bitcnt;
   logic [7:0]       rx_q, tx_q;
   logic             scl_q, sda_q;
   logic             ack_drv, tx_drv, rd_mode, nack_q;
   logic             scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_c  = scl & scl_q & sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q & sda;
   assign sda_oe   = ack_drv | (tx_drv & ~tx_q[7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sub_q     <= '0;
         ptr_q     <= '0;
         bitcnt    <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         ack_drv   <= 1'b0;
         tx_drv    <= 1'b0;
         rd_mode   <= 1'b0;
         nack_q    <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
         cal_start <= 1'b0;
         test_mode <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         cal_start <= 1'b0;
         if (start_c) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            ack_drv <= 1'b0;
            tx_drv  <= 1'b0;
         end else if (stop_c) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            ack_drv <= 1'b0;
            tx_drv  <= 1'b0;
         end else if (state != ST_IDLE) begin
            if (scl_rise) begin
               if (bitcnt < 4'd8) begin
                  rx_q   <= {rx_q[6:0], sda};
                  bitcnt <= bitcnt + 1'b1;
               end else if (bitcnt == 4'd8) begin
                  nack_q <= sda;
                  bitcnt <= 4'd9;
               end
            end else if (scl_fall) begin
               if (bitcnt == 4'd8) begin
                  unique case (state)
                     ST_ADDR: begin
                        if (rx_q[7:1] == DEV_ADDR) begin
                           ack_drv <= 1'b1;
                           rd_mode <= rx_q[0];
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     ST_SUB: begin
                        ack_drv   <= 1'b1;
                        sub_q     <= rx_q;
                        ptr_q     <= rx_q[IDX_W-1:0];
                        test_mode <= rx_q[7];
                     end
                     ST_WDATA: begin
                        ack_drv <= 1'b1;
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr_q;
                        wr_data <= rx_q;
                        if (ptr_q == '0 && !sub_q.hold) cal_start <= 1'b1;
                        if (sub_q.ainc && ptr_q != '1) ptr_q <= ptr_q + 1'b1;
                     end
                     ST_RDATA: tx_drv <= 1'b0;
                     default: ;
                  endcase
               end else if (bitcnt == 4'd9) begin
                  ack_drv <= 1'b0;
                  bitcnt  <= '0;
                  unique case (state)
                     ST_ADDR: begin
                        if (rd_mode) begin
                           state  <= ST_RDATA;
                           tx_q   <= status_i;
                           tx_drv <= 1'b1;
                        end else begin
                           state <= ST_SUB;
                        end
                     end
                     ST_SUB: state <= ST_WDATA;
                     ST_RDATA: begin
                        if (nack_q) begin
                           state <= ST_IDLE;
                        end else begin
                           tx_q   <= status_i;
                           tx_drv <= 1'b1;
                        end
                     end
                     default: ;
                  endcase
               end else if (state == ST_RDATA && bitcnt != '0) begin
                  tx_q <= {tx_q[6:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile
   import ctl_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1000110,
   parameter int         NUM_REGS    = 21,
   parameter logic [7:0] RST_VAL     = 8'hFE,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic                  mute_active_i,
   output logic                  cal_start_o,
   output logic                  test_mode_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   logic [1:0]       line_raw, line_flt;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_data;

   assign line_raw = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      ctl_i2c_glitch_filt #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (line_raw[g]),
         .dout (line_flt[g])
      );
   end

   ctl_i2c_engine #(
      .DEV_ADDR(DEV_ADDR)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (line_flt[0]),
      .sda      (line_flt[1]),
      .status_i ({7'd0, mute_active_i}),
      .sda_oe   (sda_oe_o),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .cal_start(cal_start_o),
      .test_mode(test_mode_o)
   );

   ctl_i2c_regbank #(
      .NUM_REGS(NUM_REGS),
      .RST_VAL (RST_VAL)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .regs_o (regs_o)
   );
endmodule

// File: rtl/ctl_i2c_regfile_chk.sv
module ctl_i2c_regfile_chk #(
   parameter int         NUM_REGS = 21,
   parameter logic [7:0] RST_VAL  = 8'hFE
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_oe_o,
   input logic                  cal_start_o,
   input logic [NUM_REGS*8-1:0] regs_o
);
   logic [NUM_REGS*8-1:0] prev_q;
   logic [NUM_REGS-1:0]   chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= {NUM_REGS{RST_VAL}};
      else        prev_q <= regs_o;
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
      assign chg[g] = (regs_o[g*8 +: 8] != prev_q[g*8 +: 8]);
   end

   p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> regs_o == {NUM_REGS{RST_VAL}});

   p_cal_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |=> !cal_start_o);

   p_cal_during_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |-> sda_oe_o);

   p_write_under_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |-> sda_oe_o);

   p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chg));
endmodule

bind ctl_i2c_regfile ctl_i2c_regfile_chk #(
   .NUM_REGS(NUM_REGS),
   .RST_VAL (RST_VAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sda_oe_o   (sda_oe_o),
   .cal_start_o(cal_start_o),
   .regs_o     (regs_o)
);

// File: tb/ctl_i2c_regfile_bench.sv
module ctl_i2c_regfile_bench;
   localparam int NREG = 21;
   localparam int Q    = 16;
   localparam int NVEC = 8;
   // each vector: {subaddress, first data byte, second data byte}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h23_11_22, 24'h07_33_44, 24'h34_55_66, 24'h1F_77_88,
      24'h20_A1_B2, 24'h60_C3_D4, 24'h00_01_02, 24'hA5_9A_BC
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, mute = 1'b0;
   logic sda_oe, cal_start, test_mode;
   logic [NREG*8-1:0] regs;
   logic sda_line;
   int tests = 0, fails = 0, cal_cnt = 0, exp_cal = 0;
   logic [7:0] exp_r [NREG];

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   ctl_i2c_regfile u_ctl_i2c_regfile (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .mute_active_i(mute), .cal_start_o(cal_start),
      .test_mode_o(test_mode), .regs_o(regs)
   );

   always @(posedge clk) if (rst_n && cal_start) cal_cnt++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      int bad = -1;
      for (int i = 0; i < NREG; i++)
         if (regs[i*8 +: 8] !== exp_r[i] && bad < 0) bad = i;
      if (bad < 0) check(req, 0, 0);
      else check(req, {bad[7:0], 16'd0, regs[bad*8 +: 8]}, {bad[7:0], 16'd0, exp_r[bad]});
   endtask

   task automatic qwait(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      sda_m = 1; scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait(); qwait();
   endtask

   task automatic send_bit(input logic b, input logic glitch);
      sda_m = b; qwait(); scl_m = 1;
      if (glitch) begin
         repeat (Q/2) @(negedge clk); scl_m = 0; @(negedge clk); scl_m = 1;
         repeat (Q/2 - 1) @(negedge clk);
      end else qwait();
      qwait(); scl_m = 0; qwait();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1; qwait(); scl_m = 1; qwait(); b = sda_line; qwait(); scl_m = 0; qwait();
   endtask

   task automatic send_byte(input logic [7:0] d, input logic glitch, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
      recv_bit(ack);
   endtask

   task automatic recv8(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
   endtask

   task automatic model_write(input logic [7:0] sub, input logic [7:0] d0, input logic [7:0] d1);
      logic [4:0] idx = sub[4:0];
      logic [7:0] dd [2];
      dd[0] = d0; dd[1] = d1;
      for (int k = 0; k < 2; k++) begin
         if (idx <= 5'd20) exp_r[idx] = dd[k];
         if (idx == 5'd0 && !sub[6]) exp_cal++;
         if (sub[5] && idx != 5'd31) idx = idx + 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic a0, a1, a2, a3;
      logic [7:0] rb;
      for (int i = 0; i < NREG; i++) exp_r[i] = 8'hFE;
      repeat (5) @(negedge clk);
      // R1 reset state
      check_regs("R1 reset defaults");
      check("R1 outputs idle", {sda_oe, cal_start, test_mode}, 3'b000);
      rst_n = 1;
      repeat (5) @(negedge clk);
      check_regs("R1 after reset release");

      // R3 R4 R5 R6 R7 vector walk
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] sb, d0, d1;
         {sb, d0, d1} = VEC[v];
         bus_start();
         send_byte(8'h8C, 0, a0);
         send_byte(sb, 0, a1);
         send_byte(d0, 0, a2);
         send_byte(d1, 0, a3);
         bus_stop();
         model_write(sb, d0, d1);
         check("R2 R3 R5 acks on write", {a0, a1, a2, a3}, 4'b0000);
         check_regs("R3 R4 R5 register contents");
         check("R6 calibration pulses", cal_cnt, exp_cal);
         check("R7 test mode flag", test_mode, sb[7]);
      end

      // R2 foreign address ignored
      bus_start();
      send_byte(8'h8E, 0, a0);
      send_byte(8'h22, 0, a1);
      send_byte(8'h5A, 0, a2);
      bus_stop();
      check("R2 foreign address not acked", {a0, a1, a2}, 3'b111);
      check_regs("R2 foreign write discarded");

      // R9 glitches on SCL during the data byte
      bus_start();
      send_byte(8'h8C, 0, a0);
      send_byte(8'h09, 0, a1);
      send_byte(8'h3C, 1, a2);
      bus_stop();
      model_write(8'h09, 8'h3C, 8'h3C);
      check("R9 glitched write acks", {a0, a1, a2}, 3'b000);
      check_regs("R9 glitched write stored");

      // R8 status read, resampled after ack, ended by nack
      mute = 1;
      bus_start();
      send_byte(8'h8D, 0, a0);
      check("R8 read address acked", a0, 1'b0);
      recv8(rb);
      check("R8 status with mute set", rb, 8'h01);
      mute = 0;
      send_bit(1'b0, 0);
      recv8(rb);
      check("R8 status resampled", rb, 8'h00);
      send_bit(1'b1, 0);
      check("R8 line released after nack", sda_oe, 1'b0);
      bus_stop();
      check_regs("R8 read leaves registers");

      // R1 reset again restores defaults
      rst_n = 0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < NREG; i++) exp_r[i] = 8'hFE;
      check_regs("R1 reset reloads defaults");
      check("R1 test mode cleared", test_mode, 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule